// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block catches runaway software. A prescaler divides the bus clock, and each prescaler tick steps a 15-bit down-counter. Software has to write the start register before the counter runs out. If it does not, the counter underflows and the block sends a one-cycle interrupt request. The counter then reloads and keeps counting, so the request comes back every period until software restarts the timer.

The prescaler ratio depends on the clock source and on one control bit. When the bus clock comes from the low-speed sub oscillator, the prescaler always divides by 2. When it comes from the main oscillator, control bit 7 picks divide by 16 or divide by 128. The nominal period is the ratio times 32768 bus clock cycles; for example, divide by 16 at 16 MHz gives about 32.8 ms.

After reset the prescaler and the counter are both held. The first write to the start register sets them running. Later start writes reload the counter but leave the prescaler phase as it is, so the first period after a restart can be up to one prescaler period short. The current count can be read at all times.

Top module: `wdog_timer`

## Requirements
- R1: While reset is asserted and directly after it is released, `count_o` is 7FFF hex and `irq_o` is 0.
- R2: After reset, and until the first start write, the counter holds 7FFF hex and `irq_o` stays 0, whatever the clock source.
- R3: A start write (`start_we_i` high for one cycle) sets `count_o` to 7FFF hex at the next clock edge. The value on `wr_data_i` has no effect on this.
- R4: With `sub_clk_i` = 0 and control bit 7 = 0 (written through `ctrl_we_i`, data bit 7), the counter decrements once every 16 bus clock cycles.
- R5: With `sub_clk_i` = 0 and control bit 7 = 1, the counter decrements once every 128 bus clock cycles.
- R6: With `sub_clk_i` = 1, the counter decrements once every 2 bus clock cycles, whatever the value of control bit 7.
- R7: When a prescaler tick arrives while the count is 0, `irq_o` is high for exactly one cycle, directly after that edge. This happens ratio x 32768 cycles after a start write.
- R8: On the edge where the counter underflows, it reloads 7FFF hex and keeps counting. Without a restart, the request repeats every ratio x 32768 cycles.
- R9: A start write leaves the prescaler phase unchanged. The first decrement after a restart comes at the next prescaler terminal count.
- R10: A change of clock source or of control bit 7 takes effect only after the prescaler period in progress has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sub_clk_i | input | 1 | 1 when the bus clock comes from the sub oscillator |
| ctrl_we_i | input | 1 | Write strobe for the control register |
| start_we_i | input | 1 | Write strobe for the start register |
| wr_data_i | input | 8 | Write data; control bit 7 selects the long main-clock ratio |
| count_o | output | 15 | Current counter value |
| irq_o | output | 1 | One-cycle watchdog interrupt request |

## Verification
The in-line assertions check the following on every cycle:
- the interrupt request is never longer than one cycle;
- the interrupt request comes only together with a reload to 7FFF hex;
- each tick takes exactly one step off the count;
- the counter does not move before the first start write;
- the prescaler phase stays within its latched terminal value.

Only the bench scenarios can show the rest:
- the decrement rates for each pairing of clock source and control bit;
- the full underflow period and the period that repeats after it;
- that a restart keeps the prescaler phase;
- that a ratio change waits for the next terminal count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    DIV_SUB  = 2'd0,
    DIV_LOW  = 2'd1,
    DIV_HIGH = 2'd2
  } div_sel_e;

  function automatic div_sel_e pick_div(input logic sub_clk, input logic long_sel);
    if (sub_clk)       return DIV_SUB;
    else if (long_sel) return DIV_HIGH;
    else               return DIV_LOW;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int RATIO_SUB  = 2,
  parameter int RATIO_LOW  = 16,
  parameter int RATIO_HIGH = 128
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  div_sel_e sel_i,
  output logic     tick_o
);
  localparam int PRE_W = (RATIO_HIGH > 2) ? $clog2(RATIO_HIGH) : 1;
  localparam logic [PRE_W-1:0] TERM_SUB  = PRE_W'(RATIO_SUB - 1);
  localparam logic [PRE_W-1:0] TERM_LOW  = PRE_W'(RATIO_LOW - 1);
  localparam logic [PRE_W-1:0] TERM_HIGH = PRE_W'(RATIO_HIGH - 1);

  logic [PRE_W-1:0] phase_q, phase_d;
  logic [PRE_W-1:0] term_q, term_d;
  logic [PRE_W-1:0] term_sel;
  logic             phase_en;

  always_comb begin
    case (sel_i)
      DIV_SUB:  term_sel = TERM_SUB;
      DIV_HIGH: term_sel = TERM_HIGH;
      default:  term_sel = TERM_LOW;
    endcase
  end

  assign tick_o = run_i && (phase_q == term_q);

  always_comb begin
    phase_en = 1'b1;
    phase_d  = phase_q + 1'b1;
    term_d   = term_q;
    if (!run_i) begin
      phase_d = '0;
      term_d  = term_sel;
    end else if (tick_o) begin
      phase_d = '0;
      term_d  = term_sel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      term_q  <= TERM_LOW;
    end else if (phase_en) begin
      phase_q <= phase_d;
      term_q  <= term_d;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (phase_q <= term_q)); // R9

  AST_TERM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> $stable(term_q)); // R10
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             irq_q, irq_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i || tick_i;
    cnt_d  = cnt_q;
    run_d  = run_q || start_i;
    irq_d  = 1'b0;
    if (start_i) begin
      cnt_d = RELOAD;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_d = RELOAD;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      run_q <= run_d;
      irq_q <= irq_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q); // R7

  AST_IRQ_RELOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt_q == RELOAD)); // R8

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

  AST_HELD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> ($stable(cnt_q) && !irq_q)); // R2
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 15,
  parameter int DATA_W     = 8,
  parameter int SEL_BIT    = 7,
  parameter int RATIO_SUB  = 2,
  parameter int RATIO_LOW  = 16,
  parameter int RATIO_HIGH = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sub_clk_i,
  input  logic              ctrl_we_i,
  input  logic              start_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o
);
  logic     long_q, long_d;
  logic     running;
  logic     tick;
  div_sel_e div_sel;

  always_comb begin
    long_d = ctrl_we_i ? wr_data_i[SEL_BIT] : long_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) long_q <= 1'b0;
    else         long_q <= long_d;
  end

  assign div_sel = pick_div(sub_clk_i, long_q);

  wdog_prescaler #(
    .RATIO_SUB (RATIO_SUB),
    .RATIO_LOW (RATIO_LOW),
    .RATIO_HIGH(RATIO_HIGH)
  ) i_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (running),
    .sel_i (div_sel),
    .tick_o(tick)
  );

  wdog_counter #(
    .CNT_W(CNT_W)
  ) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .start_i(start_we_i),
    .run_o  (running),
    .cnt_o  (count_o),
    .irq_o  (irq_o)
  );

  AST_START_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_we_i |=> (count_o == {CNT_W{1'b1}} && !irq_o)); // R3
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sub_clk_i;
  logic        ctrl_we_i;
  logic        start_we_i;
  logic [7:0]  wr_data_i;
  logic [14:0] count_o;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  wdog_timer i_wdog_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sub_clk_i (sub_clk_i),
    .ctrl_we_i (ctrl_we_i),
    .start_we_i(start_we_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .irq_o     (irq_o)
  );

  // vector: {sub_clk, long_sel, ratio[7:0]}
  localparam int NVEC = 5;
  localparam logic [9:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 8'd16},   // R4
    {1'b0, 1'b1, 8'd128},  // R5
    {1'b1, 1'b0, 8'd2},    // R6
    {1'b1, 1'b1, 8'd2},    // R6
    {1'b0, 1'b0, 8'd16}    // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    ctrl_we_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    ctrl_we_i = 1'b0; wr_data_i = 8'h00;
  endtask

  task automatic wr_start(input logic [7:0] d);
    start_we_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    start_we_i = 1'b0; wr_data_i = 8'h00;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; sub_clk_i = 1'b0; ctrl_we_i = 1'b0;
    start_we_i = 1'b0; wr_data_i = 8'h00;
    repeat (2) @(negedge clk_i);
    check("R1 reset count", 32'(count_o), 32'h7FFF);
    check("R1 reset irq", 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 count after release", 32'(count_o), 32'h7FFF);

    // R2: held until first start write
    sub_clk_i = 1'b1;
    repeat (300) @(negedge clk_i);
    check("R2 held count", 32'(count_o), 32'h7FFF);
    check("R2 no irq", 32'(irq_o), 32'h0);

    // table walk: decrement rate per ratio
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      sub_clk_i = VECS[v][9];
      wr_ctrl({VECS[v][8], 7'h2A});
      wr_start(8'h5C);
      repeat (int'(VECS[v][7:0]) * 5 - 1) @(negedge clk_i);
      check("R4/R5/R6 before step", 32'(count_o), 32'h7FFB);
      @(negedge clk_i);
      check("R4/R5/R6 after step", 32'(count_o), 32'h7FFA);
    end

    // R3: restart reloads, data ignored
    do_reset();
    sub_clk_i = 1'b1;
    wr_start(8'hFF);
    repeat (20) @(negedge clk_i);
    check("R3 running", 32'(count_o), 32'h7FF5);
    wr_start(8'hA5);
    check("R3 reload data A5", 32'(count_o), 32'h7FFF);
    repeat (9) @(negedge clk_i);
    wr_start(8'h00);
    check("R3 reload data 00", 32'(count_o), 32'h7FFF);

    // R9: restart keeps prescaler phase
    do_reset();
    sub_clk_i = 1'b0;
    wr_ctrl(8'h00);
    wr_start(8'h00);
    repeat (56) @(negedge clk_i);
    check("R9 before restart", 32'(count_o), 32'h7FFC);
    wr_start(8'h11);
    repeat (6) @(negedge clk_i);
    check("R9 no early step", 32'(count_o), 32'h7FFF);
    @(negedge clk_i);
    check("R9 short first period", 32'(count_o), 32'h7FFE);

    // R10: ratio change waits for terminal count
    do_reset();
    sub_clk_i = 1'b1;
    wr_ctrl(8'h00);
    wr_start(8'h00);
    @(negedge clk_i);
    sub_clk_i = 1'b0;
    @(negedge clk_i);
    check("R10 old period finishes", 32'(count_o), 32'h7FFE);
    repeat (15) @(negedge clk_i);
    check("R10 new ratio pending", 32'(count_o), 32'h7FFE);
    @(negedge clk_i);
    check("R10 new ratio applied", 32'(count_o), 32'h7FFD);

    // R7/R8: underflow pulse, reload and repeat
    do_reset();
    sub_clk_i = 1'b1;
    wr_start(8'h00);
    repeat (65535) @(negedge clk_i);
    check("R7 count zero", 32'(count_o), 32'h0);
    check("R7 no irq before", 32'(irq_o), 32'h0);
    @(negedge clk_i);
    check("R7 irq pulse", 32'(irq_o), 32'h1);
    check("R8 reload on underflow", 32'(count_o), 32'h7FFF);
    @(negedge clk_i);
    check("R7 pulse one cycle", 32'(irq_o), 32'h0);
    repeat (65535) @(negedge clk_i);
    check("R8 repeat irq", 32'(irq_o), 32'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule